// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the two software-visible registers of a small floating-point unit. The control register sets the rounding mode that the arithmetic units apply. The status register collects the five IEEE exception flags. Software reaches both through one write/read port addressed by a register select. The arithmetic units report each exception as a one-cycle event on a flag input. The block ORs every event into the status register, where it stays set until software writes that register.

Both writes are masked, so only the defined fields are stored. A parameter picks a legacy variant in which the control register keeps every bit except the flag field. In standard mode, a write that puts ones in the must-be-zero upper bits of either register raises a one-cycle error pulse, and the masked value is still stored. The arithmetic datapath and trap delivery are not part of this block.

Top module: `fpu_csr_unit`

## Requirements
- R1: After reset both registers read as zero, `round_mode` is 0 (nearest-even) and `mbz_err` is low.
- R2: A control write (`reg_sel` = 0) stores `wr_data & 0x0000007F` when `LEGACY_FCR` = 0, and `wr_data & 0xFFFFF07F` when `LEGACY_FCR` = 1. A read with `reg_sel` = 0 returns the stored value.
- R3: `round_mode` equals control bits 1:0, encoded 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. It changes only in the cycle after a control write.
- R4: `flag_evt` carries inexact at bit 0, underflow at bit 1, overflow at bit 2, divide-by-zero at bit 3 and invalid at bit 4. A read with `reg_sel` = 1 returns the five flags at bits 11:7 in that order, with every other bit zero.
- R5: A flag event is ORed into the status register at the next clock edge. The flag then stays set until a status write.
- R6: A status write (`reg_sel` = 1) replaces the flags with `wr_data` bits 11:7. Events that arrive in the same cycle are ORed into the written value.
- R7: With `LEGACY_FCR` = 0, a control or status write with any of bits 31:12 set drives `mbz_err` high for exactly the one cycle after the write edge, and the masked value is still stored. With `LEGACY_FCR` = 1, `mbz_err` never rises.
- R8: Select values 2 and 3 read as zero. Writes to them change neither register and raise no `mbz_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_sel` |
| flag_evt | input | 5 | Exception events from the datapath |
| round_mode | output | 2 | Rounding mode to the arithmetic units |
| mbz_err | output | 1 | One-cycle pulse on a must-be-zero violation |

## Verification
The assertions check several things on every cycle. The rounding output holds between control writes and loads the low two bits of each one. A flag never drops without a status write, and every event shows up in the flags one cycle later. A status write loads the written field ORed with concurrent events. The error pulse follows exactly the violating writes. The read value for the status register and the undefined selects is the expected image. Only the bench scenarios show the concrete mask values stored in each mode, the mapping of each rounding code, the legacy variant beside the standard one, and that writes to undefined selects leave both registers untouched.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_POS_INF   = 2'd2,
        RND_NEG_INF   = 2'd3
    } rnd_mode_e;

    // register select codes
    localparam int unsigned CSR_CTRL_IDX = 0;
    localparam int unsigned CSR_STAT_IDX = 1;

    // exception flag positions inside the flag field
    localparam int unsigned FLG_NX = 0;
    localparam int unsigned FLG_UF = 1;
    localparam int unsigned FLG_OF = 2;
    localparam int unsigned FLG_DZ = 3;
    localparam int unsigned FLG_NV = 4;

endpackage

// File: rtl/fpu_csr_decode.sv
module fpu_csr_decode
    import fpu_csr_pkg::*;
#(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MBZ_LSB   = 12,
    parameter bit          CHECK_MBZ = 1'b1
) (
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              mbz_hit
);

    localparam logic [DATA_W-1:0] MBZ_MASK = {DATA_W{1'b1}} << MBZ_LSB;

    logic sel_ctrl;
    logic sel_stat;
    logic upper_set;

    always_comb begin
        sel_ctrl  = (reg_sel == SEL_W'(CSR_CTRL_IDX));
        sel_stat  = (reg_sel == SEL_W'(CSR_STAT_IDX));
        wr_ctrl   = wr_en && sel_ctrl;
        wr_stat   = wr_en && sel_stat;
        upper_set = |(wr_data & MBZ_MASK);
    end

    generate
        if (CHECK_MBZ) begin : g_mbz_on
            assign mbz_hit = (wr_ctrl || wr_stat) && upper_set;
        end else begin : g_mbz_off
            logic unused_upper;
            assign unused_upper = upper_set;
            assign mbz_hit      = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fpu_csr_ctrl.sv
module fpu_csr_ctrl #(
    parameter int unsigned       DATA_W    = 32,
    parameter logic [DATA_W-1:0] KEEP_MASK = DATA_W'(32'h7F)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mbz_hit,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              mbz_err
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              mbz;
    } ctrl_state_t;

    ctrl_state_t state_d;
    ctrl_state_t state_q;

    always_comb begin
        state_d      = state_q;
        state_d.mbz  = mbz_hit;
        if (wr_ctrl) begin
            state_d.ctrl = wr_data & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_q  = state_q.ctrl;
    assign mbz_err = state_q.mbz;

endmodule

// File: rtl/fpu_csr_flags.sv
module fpu_csr_flags #(
    parameter int unsigned FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic [FLAG_W-1:0] flag_evt,
    output logic [FLAG_W-1:0] flags_q
);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;

    flag_state_t state_d;
    flag_state_t state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < int'(FLAG_W); i++) begin
            if (wr_stat) begin
                state_d.flags[i] = wr_flags[i] | flag_evt[i];
            end else begin
                state_d.flags[i] = state_q.flags[i] | flag_evt[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.flags;

endmodule

// File: rtl/fpu_csr_unit.sv
module fpu_csr_unit
    import fpu_csr_pkg::*;
#(
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned FLAG_W     = 5,
    parameter int unsigned FLAG_LSB   = 7,
    parameter bit          LEGACY_FCR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FLAG_W-1:0] flag_evt,
    output logic [1:0]        round_mode,
    output logic              mbz_err
);

    localparam int unsigned       MBZ_LSB    = FLAG_LSB + FLAG_W;
    localparam logic [DATA_W-1:0] FIELD_MASK =
        {{(DATA_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}} << FLAG_LSB;
    localparam logic [DATA_W-1:0] STD_KEEP   = ~({DATA_W{1'b1}} << FLAG_LSB);
    localparam logic [DATA_W-1:0] CTRL_KEEP  = LEGACY_FCR ? ~FIELD_MASK : STD_KEEP;

    logic              wr_ctrl;
    logic              wr_stat;
    logic              mbz_hit;
    logic [DATA_W-1:0] ctrl_q;
    logic [FLAG_W-1:0] flag_q;
    rnd_mode_e         rnd;

    fpu_csr_decode #(
        .SEL_W     (SEL_W),
        .DATA_W    (DATA_W),
        .MBZ_LSB   (MBZ_LSB),
        .CHECK_MBZ (!LEGACY_FCR)
    ) u_decode (
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .wr_ctrl (wr_ctrl),
        .wr_stat (wr_stat),
        .mbz_hit (mbz_hit)
    );

    fpu_csr_ctrl #(
        .DATA_W    (DATA_W),
        .KEEP_MASK (CTRL_KEEP)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .mbz_hit (mbz_hit),
        .ctrl_q  (ctrl_q),
        .mbz_err (mbz_err)
    );

    fpu_csr_flags #(
        .FLAG_W (FLAG_W)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stat  (wr_stat),
        .wr_flags (wr_data[FLAG_LSB +: FLAG_W]),
        .flag_evt (flag_evt),
        .flags_q  (flag_q)
    );

    always_comb begin
        rnd        = rnd_mode_e'(ctrl_q[1:0]);
        round_mode = rnd;
    end

    // combinational read mux; undefined selects read zero
    always_comb begin
        rd_data = '0;
        if (reg_sel == SEL_W'(CSR_CTRL_IDX)) begin
            rd_data = ctrl_q;
        end else if (reg_sel == SEL_W'(CSR_STAT_IDX)) begin
            rd_data = DATA_W'(flag_q) << FLAG_LSB;
        end
    end

endmodule

// File: rtl/fpu_csr_unit_chk.sv
module fpu_csr_unit_chk #(
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned FLAG_W     = 5,
    parameter int unsigned FLAG_LSB   = 7,
    parameter bit          LEGACY_FCR = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [FLAG_W-1:0] flag_evt,
    input logic [1:0]        round_mode,
    input logic              mbz_err,
    input logic [FLAG_W-1:0] flags
);

    localparam int unsigned MBZ_LSB = FLAG_LSB + FLAG_W;

    logic c_wr_ctrl;
    logic c_wr_stat;
    logic c_violate;

    always_comb begin
        c_wr_ctrl = wr_en && (reg_sel == SEL_W'(0));
        c_wr_stat = wr_en && (reg_sel == SEL_W'(1));
        c_violate = !LEGACY_FCR && (c_wr_ctrl || c_wr_stat) && (|(wr_data >> MBZ_LSB));
    end

    p_round_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr_ctrl |=> $stable(round_mode));

    p_round_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_ctrl |=> round_mode == $past(wr_data[1:0]));

    p_flags_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr_stat |=> ((flags & $past(flags)) == $past(flags)));

    p_evt_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_evt) |=> ((flags & $past(flag_evt)) == $past(flag_evt)));

    p_stat_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_stat |=> flags == ($past(wr_data[FLAG_LSB +: FLAG_W]) | $past(flag_evt)));

    p_mbz_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_violate |=> mbz_err);

    p_mbz_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !c_violate |=> !mbz_err);

    p_stat_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_W'(1)) |-> rd_data == (DATA_W'(flags) << FLAG_LSB));

    p_undef_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel > SEL_W'(1)) |-> rd_data == '0);

endmodule

bind fpu_csr_unit fpu_csr_unit_chk #(
    .SEL_W      (SEL_W),
    .DATA_W     (DATA_W),
    .FLAG_W     (FLAG_W),
    .FLAG_LSB   (FLAG_LSB),
    .LEGACY_FCR (LEGACY_FCR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .flag_evt   (flag_evt),
    .round_mode (round_mode),
    .mbz_err    (mbz_err),
    .flags      (flag_q)
);

// File: tb/fpu_csr_unit_tb_top.sv
`timescale 1ns/1ps
module fpu_csr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [4:0]  flag_evt = '0;
    logic [31:0] rd_data, rd_leg;
    logic [1:0]  round_mode, round_leg;
    logic        mbz_err, mbz_leg;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fpu_csr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .flag_evt(flag_evt),
        .round_mode(round_mode), .mbz_err(mbz_err)
    );

    fpu_csr_unit #(.LEGACY_FCR(1'b1)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_leg), .flag_evt(flag_evt),
        .round_mode(round_leg), .mbz_err(mbz_leg)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    // one-cycle access; returns just after the edge that takes it
    task automatic access(input logic we, input logic [1:0] sel, input logic [31:0] d,
                          input logic [4:0] evt);
        @(negedge clk);
        wr_en = we; reg_sel = sel; wr_data = d; flag_evt = evt;
        @(negedge clk);
        wr_en = 1'b0; flag_evt = '0;
    endtask

    task automatic peek(input logic [1:0] sel);
        reg_sel = sel;
        #0.1;
    endtask

    task automatic t_reset;
        peek(2'd0); check("R1 ctrl", rd_data, 32'h0);
        check("R1 round", {30'd0, round_mode}, 32'h0);
        check("R1 mbz", {31'd0, mbz_err}, 32'h0);
        peek(2'd1); check("R1 stat", rd_data, 32'h0);
    endtask

    task automatic t_round;
        for (int m = 0; m < 4; m++) begin
            access(1'b1, 2'd0, 32'h0000_0050 | 32'(m), '0);
            check("R3 round code", {30'd0, round_mode}, 32'(m));
            check("R2 ctrl std", rd_data, 32'h0000_0050 | 32'(m));
            access(1'b0, 2'd0, '0, '0);
            check("R3 round hold", {30'd0, round_mode}, 32'(m));
        end
    endtask

    task automatic t_ctrl_mbz;
        access(1'b1, 2'd0, 32'hFFFF_F0FE, '0);
        check("R7 mbz pulse ctrl", {31'd0, mbz_err}, 32'h1);
        check("R2 std mask", rd_data, 32'h0000_007E);
        check("R3 round after", {30'd0, round_mode}, 32'h2);
        check("R2 legacy mask", rd_leg, 32'hFFFF_F07E);
        check("R7 legacy quiet", {31'd0, mbz_leg}, 32'h0);
        @(negedge clk);
        check("R7 pulse ends", {31'd0, mbz_err}, 32'h0);
        access(1'b1, 2'd0, 32'hABCD_EFFF, '0);
        check("R2 legacy mask 2", rd_leg, 32'hABCD_E07F);
        check("R3 legacy round", {30'd0, round_leg}, 32'h3);
        access(1'b1, 2'd0, 32'h0000_0003, '0);
        check("R7 no pulse clean", {31'd0, mbz_err}, 32'h0);
    endtask

    task automatic t_flags;
        access(1'b1, 2'd1, 32'h0, '0);
        access(1'b0, 2'd1, '0, 5'b00001);
        check("R4 inexact bit7", rd_data, 32'h0000_0080);
        access(1'b0, 2'd1, '0, 5'b10000);
        check("R5 sticky invalid", rd_data, 32'h0000_0880);
        access(1'b0, 2'd1, '0, 5'b01100);
        check("R4 ovf dz", rd_data, 32'h0000_0E80);
        access(1'b0, 2'd1, '0, '0);
        check("R5 hold", rd_data, 32'h0000_0E80);
    endtask

    task automatic t_stat_write;
        access(1'b1, 2'd1, 32'h0000_0500, '0);
        check("R6 write field", rd_data, 32'h0000_0500);
        access(1'b1, 2'd1, 32'h0000_007F, '0);
        check("R6 clear", rd_data, 32'h0);
        access(1'b1, 2'd1, 32'h0000_0100, 5'b10000);
        check("R6 write or evt", rd_data, 32'h0000_0900);
        access(1'b1, 2'd1, 32'h8000_0F80, '0);
        check("R7 mbz pulse stat", {31'd0, mbz_err}, 32'h1);
        check("R7 masked stored", rd_data, 32'h0000_0F80);
        check("R7 legacy stat quiet", {31'd0, mbz_leg}, 32'h0);
    endtask

    task automatic t_undef;
        access(1'b1, 2'd2, 32'hFFFF_FFFF, '0);
        check("R8 no mbz", {31'd0, mbz_err}, 32'h0);
        check("R8 sel2 zero", rd_data, 32'h0);
        access(1'b1, 2'd3, 32'hFFFF_FFFF, '0);
        check("R8 sel3 zero", rd_data, 32'h0);
        peek(2'd0); check("R8 ctrl untouched", rd_data, 32'h0000_0003);
        peek(2'd1); check("R8 stat untouched", rd_data, 32'h0000_0F80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_round();
        t_ctrl_mbz();
        t_flags();
        t_stat_write();
        t_undef();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule